// File: doc/BRIEF.md
# Compound Pointer Register File

This block keeps a bank of compound pointer registers for a stack-oriented execution unit. Each register bundles three words: a memory pointer, a stride that is added or subtracted on stepping accesses, and a limit that marks the end of the array being walked. One operation arrives per cycle as a 5-bit opcode with a register select, a 2-bit type field and a write word. The operand stack and the memory port are outside the block. The block supplies the memory address and the direction of the transfer. It accepts field values popped from the stack and returns field values to be pushed onto it.

An array access presents the current pointer as the memory address in the same cycle. It can then leave the pointer alone, move it forward by the stride, or move it back by the stride. After a stepping access, the new pointer is compared with the limit. The result is held in a flag that software-visible loop logic can test. Pointer-field transfers require a zero type field. Any other encoding, and any unassigned opcode, raises an illegal-instruction indication and changes nothing.

Top module: `cptr_regfile`

## Requirements
- R1: After reset, the pointer, stride and limit of every register read as zero, and `lim_hit` is 0.
- R2: Opcodes 00000 (array to stack) and 00001 (stack to array) assert `mem_req` in the same cycle with `mem_addr` equal to the selected pointer, and `mem_we` equal to opcode bit 0. The pointer is unchanged.
- R3: Opcodes 00100 and 00101 access memory as in R2 at the pointer's old value, and on the clock edge set the pointer to pointer + stride, modulo 2^AW.
- R4: Opcodes 00110 and 00111 access memory as in R2 at the pointer's old value, and on the clock edge set the pointer to pointer - stride, modulo 2^AW.
- R5: After an advancing access, `lim_hit` becomes 1 when the new pointer is >= the limit (unsigned) and 0 otherwise. After a retreating access it becomes 1 when the new pointer is <= the limit. Every other cycle leaves it unchanged.
- R6: Opcodes 11000, 11001 and 11010 load `wdata` into the limit, the stride and the pointer respectively of the selected register, effective from the next cycle.
- R7: Opcodes 11100, 11101 and 11110 assert `rd_valid` in the same cycle with `rd_data` equal to the limit, the stride and the pointer respectively, as held at the start of that cycle. `rd_data` is 0 when `rd_valid` is 0.
- R8: A pointer-field opcode (bits 4:3 = 11) with a nonzero `type_field` asserts `illegal` in the same cycle, produces no read and alters no register.
- R9: Every opcode not listed in R2 to R7 asserts `illegal` and has no effect. This includes 00010, 00011, 11011, 11111 and all of 01xxx and 10xxx.
- R10: The type field does not affect array accesses (R2 to R4).
- R11: With `op_valid` low, `mem_req`, `rd_valid` and `illegal` are 0 and no state changes.
- R12: An operation changes only the register named by `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 5 | Operation code |
| type_field | input | TW (2) | Operand type; must be zero for pointer-field operations |
| reg_sel | input | 3 | Selected compound register |
| wdata | input | AW (32) | Value popped from the operand stack |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Access writes memory (stack to array) |
| mem_addr | output | AW (32) | Access address; 0 when no request |
| rd_valid | output | 1 | `rd_data` carries a field value |
| rd_data | output | AW (32) | Field value to push onto the stack |
| illegal | output | 1 | Rejected operation |
| lim_hit | output | 1 | Limit reached by the last stepping access |

## Verification
A stepping access does two things in one cycle: it drives the address from the pointer's old value, and it commits the stepped pointer at the edge that closes the same cycle. The limit compare uses the stepped value in that same cycle. The bench issues advancing and retreating accesses and checks `mem_addr` before the edge. It then checks `lim_hit` after the edge, and a later pointer read confirms the committed value. The chosen values put the stepped pointer exactly on the limit, just short of it, and across the 2^AW wrap in both directions, so that each of the two functions is judged against values worked out from the requirements.

// File: rtl/cptr_pkg.sv
package cptr_pkg;

    localparam logic [4:0] OP_ACC_LOAD  = 5'b00000;
    localparam logic [4:0] OP_ACC_STORE = 5'b00001;
    localparam logic [4:0] OP_ADV_LOAD  = 5'b00100;
    localparam logic [4:0] OP_ADV_STORE = 5'b00101;
    localparam logic [4:0] OP_RET_LOAD  = 5'b00110;
    localparam logic [4:0] OP_RET_STORE = 5'b00111;
    localparam logic [4:0] OP_SET_LIM   = 5'b11000;
    localparam logic [4:0] OP_SET_STR   = 5'b11001;
    localparam logic [4:0] OP_SET_PTR   = 5'b11010;
    localparam logic [4:0] OP_GET_LIM   = 5'b11100;
    localparam logic [4:0] OP_GET_STR   = 5'b11101;
    localparam logic [4:0] OP_GET_PTR   = 5'b11110;

    typedef enum logic [1:0] {
        FLD_LIM = 2'd0,
        FLD_STR = 2'd1,
        FLD_PTR = 2'd2
    } fld_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_ADV  = 2'd1,
        STEP_RET  = 2'd2
    } step_e;

    typedef struct packed {
        logic  access;
        logic  mem_wr;
        step_e step;
        logic  fld_wr;
        logic  fld_rd;
        fld_e  fld;
        logic  illegal;
    } ctl_t;

endpackage

// File: rtl/cptr_decode.sv
module cptr_decode
    import cptr_pkg::*;
#(
    parameter int TW = 2
) (
    input  logic          op_valid,
    input  logic [4:0]    opcode,
    input  logic [TW-1:0] type_field,
    output ctl_t          ctl
);

    logic type_zero;
    logic field_op;

    assign type_zero = (type_field == '0);
    assign field_op  = (opcode[4:3] == 2'b11);

    always_comb begin
        ctl = '0;
        if (op_valid) begin
            unique case (opcode)
                OP_ACC_LOAD, OP_ACC_STORE: begin
                    ctl.access = 1'b1;
                    ctl.mem_wr = opcode[0];
                end
                OP_ADV_LOAD, OP_ADV_STORE: begin
                    ctl.access = 1'b1;
                    ctl.mem_wr = opcode[0];
                    ctl.step   = STEP_ADV;
                end
                OP_RET_LOAD, OP_RET_STORE: begin
                    ctl.access = 1'b1;
                    ctl.mem_wr = opcode[0];
                    ctl.step   = STEP_RET;
                end
                OP_SET_LIM: begin
                    ctl.fld_wr = 1'b1;
                    ctl.fld    = FLD_LIM;
                end
                OP_SET_STR: begin
                    ctl.fld_wr = 1'b1;
                    ctl.fld    = FLD_STR;
                end
                OP_SET_PTR: begin
                    ctl.fld_wr = 1'b1;
                    ctl.fld    = FLD_PTR;
                end
                OP_GET_LIM: begin
                    ctl.fld_rd = 1'b1;
                    ctl.fld    = FLD_LIM;
                end
                OP_GET_STR: begin
                    ctl.fld_rd = 1'b1;
                    ctl.fld    = FLD_STR;
                end
                OP_GET_PTR: begin
                    ctl.fld_rd = 1'b1;
                    ctl.fld    = FLD_PTR;
                end
                default: begin
                    ctl.illegal = 1'b1;
                end
            endcase
            // a field operation with a nonzero type is rejected whole
            if (field_op && !type_zero) begin
                ctl = '0;
                ctl.illegal = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cptr_step.sv
module cptr_step
    import cptr_pkg::*;
#(
    parameter int AW         = 32,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  step_e         dir,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] stride,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] nxt,
    output logic          hit
);

    logic ge_lim;
    logic le_lim;

    always_comb begin
        unique case (dir)
            STEP_ADV: nxt = ptr + stride;
            STEP_RET: nxt = ptr - stride;
            default:  nxt = ptr;
        endcase
    end

    generate
        if (SIGNED_CMP) begin : g_signed
            assign ge_lim = ($signed(nxt) >= $signed(limit));
            assign le_lim = ($signed(nxt) <= $signed(limit));
        end else begin : g_unsigned
            assign ge_lim = (nxt >= limit);
            assign le_lim = (nxt <= limit);
        end
    endgenerate

    always_comb begin
        unique case (dir)
            STEP_ADV: hit = ge_lim;
            STEP_RET: hit = le_lim;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cptr_bank.sv
module cptr_bank
    import cptr_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl,
    input  logic [SW-1:0] sel,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] step_nxt,
    input  logic          step_hit,
    output logic [AW-1:0] cur_ptr,
    output logic [AW-1:0] cur_str,
    output logic [AW-1:0] cur_lim,
    output logic          lim_hit
);

    typedef struct packed {
        logic [NREG-1:0][AW-1:0] lim;
        logic [NREG-1:0][AW-1:0] str;
        logic [NREG-1:0][AW-1:0] ptr;
        logic                    hit;
    } st_t;

    st_t st_d;
    st_t st_q;

    logic [NREG-1:0] hot;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_hot
            assign hot[g] = (sel == SW'(g));
        end
    endgenerate

    assign cur_ptr = st_q.ptr[sel];
    assign cur_str = st_q.str[sel];
    assign cur_lim = st_q.lim[sel];
    assign lim_hit = st_q.hit;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (hot[i]) begin
                if (ctl.fld_wr) begin
                    unique case (ctl.fld)
                        FLD_LIM: st_d.lim[i] = wdata;
                        FLD_STR: st_d.str[i] = wdata;
                        FLD_PTR: st_d.ptr[i] = wdata;
                        default: ;
                    endcase
                end
                if (ctl.step != STEP_NONE) begin
                    st_d.ptr[i] = step_nxt;
                end
            end
        end
        if (ctl.step != STEP_NONE) begin
            st_d.hit = step_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cptr_regfile.sv
module cptr_regfile
    import cptr_pkg::*;
#(
    parameter int NREG       = 8,
    parameter int AW         = 32,
    parameter int TW         = 2,
    parameter bit SIGNED_CMP = 1'b0,
    localparam int SW        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    opcode,
    input  logic [TW-1:0] type_field,
    input  logic [SW-1:0] reg_sel,
    input  logic [AW-1:0] wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          rd_valid,
    output logic [AW-1:0] rd_data,
    output logic          illegal,
    output logic          lim_hit
);

    ctl_t          ctl;
    logic [AW-1:0] cur_ptr;
    logic [AW-1:0] cur_str;
    logic [AW-1:0] cur_lim;
    logic [AW-1:0] step_nxt;
    logic          step_hit;

    cptr_decode #(.TW(TW)) u_decode (
        .op_valid   (op_valid),
        .opcode     (opcode),
        .type_field (type_field),
        .ctl        (ctl)
    );

    cptr_bank #(.NREG(NREG), .AW(AW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .sel      (reg_sel),
        .wdata    (wdata),
        .step_nxt (step_nxt),
        .step_hit (step_hit),
        .cur_ptr  (cur_ptr),
        .cur_str  (cur_str),
        .cur_lim  (cur_lim),
        .lim_hit  (lim_hit)
    );

    cptr_step #(.AW(AW), .SIGNED_CMP(SIGNED_CMP)) u_step (
        .dir    (ctl.step),
        .ptr    (cur_ptr),
        .stride (cur_str),
        .limit  (cur_lim),
        .nxt    (step_nxt),
        .hit    (step_hit)
    );

    assign mem_req  = ctl.access;
    assign mem_we   = ctl.access & ctl.mem_wr;
    assign mem_addr = ctl.access ? cur_ptr : '0;
    assign rd_valid = ctl.fld_rd;
    assign illegal  = ctl.illegal;

    always_comb begin
        rd_data = '0;
        if (ctl.fld_rd) begin
            unique case (ctl.fld)
                FLD_LIM: rd_data = cur_lim;
                FLD_STR: rd_data = cur_str;
                FLD_PTR: rd_data = cur_ptr;
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/cptr_regfile_chk.sv
module cptr_regfile_chk #(
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [4:0]    opcode,
    input logic [TW-1:0] type_field,
    input logic          mem_req,
    input logic          mem_we,
    input logic          rd_valid,
    input logic          illegal,
    input logic          lim_hit
);

    logic stepping;
    assign stepping = op_valid && (opcode[4:2] == 3'b001);

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, rd_valid, illegal})); // R9

    AST_FIELD_TYPE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[4:3] == 2'b11 && type_field != '0) |-> (illegal && !rd_valid)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!mem_req && !rd_valid && !illegal)); // R11

    AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stepping |=> $stable(lim_hit)); // R5

    AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R2

    AST_STEP_ACCESSES: assert property (@(posedge clk) disable iff (!rst_n)
        stepping |-> (mem_req && mem_we == opcode[0])); // R3

endmodule

bind cptr_regfile cptr_regfile_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .type_field (type_field),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .rd_valid   (rd_valid),
    .illegal    (illegal),
    .lim_hit    (lim_hit)
);

// File: tb/cptr_regfile_tb.sv
module cptr_regfile_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    typedef struct packed {
        logic [4:0]  op;
        logic [1:0]  ty;
        logic [2:0]  sel;
        logic [31:0] wd;
        logic        e_req;
        logic        e_we;
        logic [31:0] e_addr;
        logic        e_rdv;
        logic [31:0] e_rd;
        logic        e_ill;
        logic        e_hit;
    } vec_t;

    // op ty sel wdata | req we addr | rdv rd | ill | hit after edge
    localparam logic [110:0] VEC [0:NV-1] = '{
        {5'b11010, 2'd0, 3'd1, 32'h100,  1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0},
        {5'b11001, 2'd0, 3'd1, 32'h10,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0},
        {5'b11000, 2'd0, 3'd1, 32'h120,  1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0},
        {5'b11110, 2'd0, 3'd1, 32'h0,    1'b0, 1'b0, 32'h0,   1'b1, 32'h100, 1'b0, 1'b0},
        {5'b00000, 2'd2, 3'd1, 32'h0,    1'b1, 1'b0, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0},
        {5'b00101, 2'd0, 3'd1, 32'h0,    1'b1, 1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0},
        {5'b00100, 2'd1, 3'd1, 32'h0,    1'b1, 1'b0, 32'h110, 1'b0, 32'h0,   1'b0, 1'b1},
        {5'b00001, 2'd0, 3'd1, 32'h0,    1'b1, 1'b1, 32'h120, 1'b0, 32'h0,   1'b0, 1'b1},
        {5'b00110, 2'd0, 3'd1, 32'h0,    1'b1, 1'b0, 32'h120, 1'b0, 32'h0,   1'b0, 1'b1},
        {5'b11000, 2'd0, 3'd1, 32'hF0,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b1},
        {5'b00111, 2'd0, 3'd1, 32'h0,    1'b1, 1'b1, 32'h110, 1'b0, 32'h0,   1'b0, 1'b0},
        {5'b00110, 2'd3, 3'd1, 32'h0,    1'b1, 1'b0, 32'h100, 1'b0, 32'h0,   1'b0, 1'b1},
        {5'b11101, 2'd1, 3'd1, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 1'b1},
        {5'b11010, 2'd3, 3'd1, 32'hDEAD, 1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 1'b1},
        {5'b11110, 2'd0, 3'd1, 32'h0,    1'b0, 1'b0, 32'h0,   1'b1, 32'hF0,  1'b0, 1'b1},
        {5'b11100, 2'd0, 3'd1, 32'h0,    1'b0, 1'b0, 32'h0,   1'b1, 32'hF0,  1'b0, 1'b1},
        {5'b11101, 2'd0, 3'd1, 32'h0,    1'b0, 1'b0, 32'h0,   1'b1, 32'h10,  1'b0, 1'b1},
        {5'b11110, 2'd0, 3'd0, 32'h0,    1'b0, 1'b0, 32'h0,   1'b1, 32'h0,   1'b0, 1'b1},
        {5'b00010, 2'd0, 3'd0, 32'h55,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 1'b1},
        {5'b11111, 2'd0, 3'd1, 32'h77,   1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 1'b1},
        {5'b01000, 2'd0, 3'd1, 32'h0,    1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 1'b1},
        {5'b11110, 2'd0, 3'd1, 32'h0,    1'b0, 1'b0, 32'h0,   1'b1, 32'hF0,  1'b0, 1'b1}
    };

    logic        clk;
    logic        rst_n;
    logic        op_valid;
    logic [4:0]  opcode;
    logic [1:0]  type_field;
    logic [2:0]  reg_sel;
    logic [31:0] wdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        illegal;
    logic        lim_hit;

    int n_chk;
    int n_fail;
    bit done;

    cptr_regfile u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .opcode     (opcode),
        .type_field (type_field),
        .reg_sel    (reg_sel),
        .wdata      (wdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .illegal    (illegal),
        .lim_hit    (lim_hit)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string tag_of(input logic [4:0] op, input logic [1:0] ty);
        if (op[4:3] == 2'b11 && ty != 2'd0) return "R8";
        case (op)
            5'b00000, 5'b00001: return (ty != 2'd0) ? "R10" : "R2";
            5'b00100, 5'b00101: return (ty != 2'd0) ? "R10" : "R3";
            5'b00110, 5'b00111: return (ty != 2'd0) ? "R10" : "R4";
            5'b11000, 5'b11001, 5'b11010: return "R6";
            5'b11100, 5'b11101, 5'b11110: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic [4:0] op, input logic [1:0] ty,
                       input logic [2:0] sel, input logic [31:0] wd);
        @(negedge clk);
        op_valid   = v;
        opcode     = op;
        type_field = ty;
        reg_sel    = sel;
        wdata      = wd;
        #1;
    endtask

    task automatic finish_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic read_field(input logic [4:0] op, input logic [2:0] sel,
                              input logic [31:0] exp, input string tag);
        put(1'b1, op, 2'd0, sel, 32'h0);
        check(tag, "read valid", {31'b0, rd_valid}, 32'd1);
        check(tag, "read data", rd_data, exp);
        finish_edge();
    endtask

    task automatic write_field(input logic [4:0] op, input logic [2:0] sel,
                               input logic [31:0] wd);
        put(1'b1, op, 2'd0, sel, wd);
        finish_edge();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        n_chk = 0;
        n_fail = 0;
        done = 1'b0;
        rst_n = 1'b0;
        op_valid = 1'b0;
        opcode = '0;
        type_field = '0;
        reg_sel = '0;
        wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", "lim_hit after reset", {31'b0, lim_hit}, 32'd0);
        for (int r = 0; r < 8; r++) begin
            read_field(5'b11100, 3'(r), 32'h0, "R1");
            read_field(5'b11101, 3'(r), 32'h0, "R1");
            read_field(5'b11110, 3'(r), 32'h0, "R1");
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VEC[i];
            t = tag_of(v.op, v.ty);
            put(1'b1, v.op, v.ty, v.sel, v.wd);
            check(t, "mem_req", {31'b0, mem_req}, {31'b0, v.e_req});
            check(t, "mem_we", {31'b0, mem_we}, {31'b0, v.e_we});
            check(t, "mem_addr", mem_addr, v.e_addr);
            check(t, "rd_valid", {31'b0, rd_valid}, {31'b0, v.e_rdv});
            check(t, "rd_data", rd_data, v.e_rd);
            check(t, "illegal", {31'b0, illegal}, {31'b0, v.e_ill});
            finish_edge();
            check((v.op[4:2] == 3'b001) ? "R5" : t, "lim_hit", {31'b0, lim_hit}, {31'b0, v.e_hit});
        end

        // R11: idle cycle with a stepping opcode on the pins
        put(1'b0, 5'b00101, 2'd0, 3'd1, 32'h0);
        check("R11", "mem_req idle", {31'b0, mem_req}, 32'd0);
        check("R11", "illegal idle", {31'b0, illegal}, 32'd0);
        finish_edge();
        read_field(5'b11110, 3'd1, 32'hF0, "R11");

        // R3 wrap and R12 isolation on register 7
        write_field(5'b11010, 3'd7, 32'hFFFF_FFF8);
        write_field(5'b11001, 3'd7, 32'h10);
        put(1'b1, 5'b00100, 2'd0, 3'd7, 32'h0);
        check("R3", "wrap addr", mem_addr, 32'hFFFF_FFF8);
        finish_edge();
        check("R5", "hit after wrap advance", {31'b0, lim_hit}, 32'd1);
        read_field(5'b11110, 3'd7, 32'h8, "R3");
        read_field(5'b11110, 3'd1, 32'hF0, "R12");
        read_field(5'b11101, 3'd6, 32'h0, "R12");

        // R4 wrap on register 2
        write_field(5'b11010, 3'd2, 32'h4);
        write_field(5'b11001, 3'd2, 32'h8);
        write_field(5'b11000, 3'd2, 32'hFFFF_FFF0);
        put(1'b1, 5'b00111, 2'd0, 3'd2, 32'h0);
        check("R4", "wrap addr", mem_addr, 32'h4);
        check("R4", "store dir", {31'b0, mem_we}, 32'd1);
        finish_edge();
        check("R5", "no hit after wrap retreat", {31'b0, lim_hit}, 32'd0);
        read_field(5'b11110, 3'd2, 32'hFFFF_FFFC, "R4");
        read_field(5'b11110, 3'd7, 32'h8, "R12");

        put(1'b0, 5'b00000, 2'd0, 3'd0, 32'h0);
        finish_edge();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule